// File: doc/BRIEF.md
# Programmed-IO Byte FIFO with Command Capture

This block holds the bytes that a host moves one at a time through a single register while no DMA engine is involved. The host writes bytes in and reads bytes out through one byte-wide port. The block keeps a signed occupancy count that the surrounding register block can read. A status-response load from the bus side preloads a two-byte reply. Every read that finds data raises a one-cycle interrupt request.

When command-capture mode is on, host writes do not enter the FIFO. They go to a separate command buffer, which has its own length counter. The register block can read this buffer back by index.

Two status-phase bits decide what a read returns. In the data-out phase a read returns zero and leaves the read pointer in place, although the count still drops. In every other phase a read returns the stored byte. The FIFO holds at most one byte less than its storage depth. Both pointers go back to slot 0 whenever the count reaches zero.

Top module: `pio_fifo`

## Requirements
- R1: After reset, `count`, `host_rdata`, `irq_req`, `overrun`, `flags` and `cmd_len` are all zero.
- R2: A host write with `cmd_mode` low, while `count` is below DEPTH-1, has the following effect. The byte is stored at the write pointer, the pointer advances modulo DEPTH and `count` rises by one. Reads in a data-in phase return the stored bytes in the order they were written.
- R3: A host write with `cmd_mode` low, while `count` equals DEPTH-1, is dropped and sets `overrun`. `overrun` stays set until a `flush` cycle clears it, and `flush` wins over a new overrun in the same cycle. `flush` also clears `flags` and leaves the stored data and `count` unchanged.
- R4: A host write with `cmd_mode` high stores the byte in the command buffer at index `cmd_len` and increments `cmd_len`, leaving `count` unchanged. Such a write is dropped when `cmd_len` equals CMD_DEPTH. `cmd_clr` zeroes `cmd_len`, and it wins over a capture in the same cycle. `cmd_rdata` shows buffer entry `cmd_raddr` combinationally.
- R5: A host read while `count` is above zero decrements `count` and pulses `irq_req` high for the one cycle after the read edge.
- R6: A read while `phase_hi` equals 2'b00 (data-out) and `count` is above zero returns 0 in `host_rdata` and decrements `count`, but does not advance the read pointer. The next data-in read therefore returns the byte that was next before that read.
- R7: A host read while `count` is zero leaves `host_rdata` at its previous value, raises no `irq_req` and leaves `count` at zero.
- R8: When a read brings `count` to zero, both pointers return to slot 0. The next written byte is stored in slot 0 and is the next byte read.
- R9: `resp_load` takes priority over any host access in the same cycle. It stores `resp_code` in slot 0 and 0 in slot 1, sets both pointers to 0, sets `count` to 2 and sets `flags` to 2. `flags` wins over a `flush` in the same cycle.
- R10: A cycle in which `host_rd` and `host_wr` are both high performs only the read. The write byte is ignored.
- R11: `host_rdata` and `irq_req` are registered. They change only at the clock edge that samples the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the FIFO register |
| host_rd | input | 1 | Host read strobe for the FIFO register |
| host_wdata | input | DATA_W | Host write byte |
| host_rdata | output | DATA_W | Byte returned by the last successful read |
| phase_hi | input | 2 | Status phase bits [2:1]; 2'b00 means data-out |
| cmd_mode | input | 1 | Route host writes into the command buffer |
| cmd_clr | input | 1 | Zero the command length |
| cmd_raddr | input | $clog2(CMD_DEPTH) | Command buffer read index |
| cmd_rdata | output | DATA_W | Command buffer entry at `cmd_raddr` |
| cmd_len | output | $clog2(CMD_DEPTH)+1 | Number of captured command bytes |
| resp_load | input | 1 | Preload the two-byte status response |
| resp_code | input | DATA_W | Status code placed in slot 0 |
| flush | input | 1 | Clear `overrun` and `flags` |
| count | output | $clog2(DEPTH)+2 | Signed occupancy count |
| overrun | output | 1 | Sticky dropped-write flag |
| flags | output | DATA_W | Flags value, 2 after a response load |
| irq_req | output | 1 | One-cycle pulse per successful read |

## Verification
The hardest state to reach is the one where the pointers have drifted apart from the count. It needs data-out reads that drain the count without moving the read pointer, followed by enough writes to wrap the write pointer, all before the FIFO empties and the pointers snap back. The random part of the stimulus runs in epochs with a skewed write/read ratio and a random phase on every cycle, so long write-heavy stretches mixed with data-out reads build up that drift and also press against the DEPTH-1 limit. Directed sequences then cover the cases the random traffic reaches only rarely: the snap-back after draining, the command buffer filling to its limit, and the response load colliding with host access and with `flush`.

// File: rtl/pio_fifo_pkg.sv
package pio_fifo_pkg;
   typedef enum logic [1:0] {
      RK_NONE  = 2'd0,
      RK_EMPTY = 2'd1,
      RK_ZERO  = 2'd2,
      RK_DATA  = 2'd3
   } rd_kind_t;
endpackage

// File: rtl/pio_fifo_store.sv
module pio_fifo_store #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ld_en,
   input  logic [DATA_W-1:0] ld_b0,
   input  logic [DATA_W-1:0] ld_b1,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] cells [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      logic [DATA_W-1:0] cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cell_q <= '0;
         else if (ld_en && i == 0)
            cell_q <= ld_b0;
         else if (ld_en && i == 1)
            cell_q <= ld_b1;
         else if (!ld_en && wr_en && wr_addr == AW'(i))
            cell_q <= wr_data;
      end
      assign cells[i] = cell_q;
   end

   assign rd_data = cells[rd_addr];
endmodule

// File: rtl/pio_fifo_ctrl.sv
module pio_fifo_ctrl
   import pio_fifo_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_wr,
   input  logic                 host_rd,
   input  logic                 cmd_mode,
   input  logic                 phase_do,
   input  logic                 resp_load,
   input  logic                 flush,
   output logic                 fifo_wr,
   output logic                 cap_en,
   output logic [AW-1:0]        wptr,
   output logic [AW-1:0]        rptr,
   output rd_kind_t             rd_kind,
   output logic signed [CW-1:0] count,
   output logic                 overrun
);
   localparam logic signed [CW-1:0] LIMIT    = CW'(DEPTH - 1);
   localparam logic signed [CW-1:0] RESP_CNT = CW'(2);
   localparam logic signed [CW-1:0] ONE      = CW'(1);

   logic rd_go, wr_go, at_limit, ovr_hit, rd_take;
   logic signed [CW-1:0] count_dec;

   assign rd_go     = host_rd && !resp_load;
   assign wr_go     = host_wr && !host_rd && !resp_load;
   assign at_limit  = (count == LIMIT);
   assign fifo_wr   = wr_go && !cmd_mode && !at_limit;
   assign ovr_hit   = wr_go && !cmd_mode && at_limit;
   assign cap_en    = wr_go && cmd_mode;
   assign count_dec = count - ONE;

   always_comb begin
      if (!rd_go)
         rd_kind = RK_NONE;
      else if (count <= 0)
         rd_kind = RK_EMPTY;
      else if (phase_do)
         rd_kind = RK_ZERO;
      else
         rd_kind = RK_DATA;
   end

   assign rd_take = (rd_kind == RK_ZERO) || (rd_kind == RK_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (resp_load) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= RESP_CNT;
      end else if (rd_take) begin
         count <= count_dec;
         if (count_dec == 0) begin
            wptr <= '0;
            rptr <= '0;
         end else if (rd_kind == RK_DATA) begin
            rptr <= rptr + AW'(1);
         end
      end else if (fifo_wr) begin
         wptr  <= wptr + AW'(1);
         count <= count + ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         overrun <= 1'b0;
      else if (flush)
         overrun <= 1'b0;
      else if (ovr_hit)
         overrun <= 1'b1;
   end
endmodule

// File: rtl/pio_cmd_capture.sv
module pio_cmd_capture #(
   parameter int CMD_DEPTH = 16,
   parameter int DATA_W    = 8,
   localparam int CIW      = $clog2(CMD_DEPTH),
   localparam int CLW      = CIW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic [DATA_W-1:0] cap_data,
   input  logic              clr,
   input  logic [CIW-1:0]    raddr,
   output logic [DATA_W-1:0] rdata,
   output logic [CLW-1:0]    len
);
   logic [DATA_W-1:0] slots [CMD_DEPTH];
   logic              take;

   assign take = cap_en && !clr && (len < CLW'(CMD_DEPTH));

   for (genvar i = 0; i < CMD_DEPTH; i++) begin : g_slot
      logic [DATA_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (take && len[CIW-1:0] == CIW'(i))
            slot_q <= cap_data;
      end
      assign slots[i] = slot_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         len <= '0;
      else if (clr)
         len <= '0;
      else if (take)
         len <= len + CLW'(1);
   end

   assign rdata = slots[raddr];
endmodule

// File: rtl/pio_fifo.sv
module pio_fifo
   import pio_fifo_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int CMD_DEPTH = 16,
   parameter int DATA_W    = 8,
   localparam int AW       = $clog2(DEPTH),
   localparam int CW       = AW + 2,
   localparam int CIW      = $clog2(CMD_DEPTH),
   localparam int CLW      = CIW + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_wr,
   input  logic                 host_rd,
   input  logic [DATA_W-1:0]    host_wdata,
   output logic [DATA_W-1:0]    host_rdata,
   input  logic [1:0]           phase_hi,
   input  logic                 cmd_mode,
   input  logic                 cmd_clr,
   input  logic [CIW-1:0]       cmd_raddr,
   output logic [DATA_W-1:0]    cmd_rdata,
   output logic [CLW-1:0]       cmd_len,
   input  logic                 resp_load,
   input  logic [DATA_W-1:0]    resp_code,
   input  logic                 flush,
   output logic signed [CW-1:0] count,
   output logic                 overrun,
   output logic [DATA_W-1:0]    flags,
   output logic                 irq_req
);
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("pio_fifo: DEPTH must be a power of two, at least 4");
   end
   if (CMD_DEPTH < 2 || (CMD_DEPTH & (CMD_DEPTH - 1)) != 0) begin : g_bad_cmd
      $error("pio_fifo: CMD_DEPTH must be a power of two, at least 2");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("pio_fifo: DATA_W must hold the flags value 2");
   end

   localparam logic [DATA_W-1:0] RESP_FLAGS = DATA_W'(2);

   logic              fifo_wr, cap_en;
   logic [AW-1:0]     s_wptr, s_rptr;
   logic [DATA_W-1:0] store_q;
   rd_kind_t          rd_kind;

   pio_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_wr   (host_wr),
      .host_rd   (host_rd),
      .cmd_mode  (cmd_mode),
      .phase_do  (phase_hi == 2'b00),
      .resp_load (resp_load),
      .flush     (flush),
      .fifo_wr   (fifo_wr),
      .cap_en    (cap_en),
      .wptr      (s_wptr),
      .rptr      (s_rptr),
      .rd_kind   (rd_kind),
      .count     (count),
      .overrun   (overrun)
   );

   pio_fifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (fifo_wr),
      .wr_addr (s_wptr),
      .wr_data (host_wdata),
      .ld_en   (resp_load),
      .ld_b0   (resp_code),
      .ld_b1   ('0),
      .rd_addr (s_rptr),
      .rd_data (store_q)
   );

   pio_cmd_capture #(.CMD_DEPTH(CMD_DEPTH), .DATA_W(DATA_W)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (cap_en),
      .cap_data (host_wdata),
      .clr      (cmd_clr),
      .raddr    (cmd_raddr),
      .rdata    (cmd_rdata),
      .len      (cmd_len)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_rdata <= '0;
         irq_req    <= 1'b0;
      end else begin
         irq_req <= (rd_kind == RK_DATA) || (rd_kind == RK_ZERO);
         if (rd_kind == RK_DATA)
            host_rdata <= store_q;
         else if (rd_kind == RK_ZERO)
            host_rdata <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flags <= '0;
      else if (resp_load)
         flags <= RESP_FLAGS;
      else if (flush)
         flags <= '0;
   end
endmodule

// File: rtl/pio_fifo_chk.sv
module pio_fifo_chk #(
   parameter int DEPTH     = 16,
   parameter int CMD_DEPTH = 16,
   parameter int DATA_W    = 8,
   localparam int AW       = $clog2(DEPTH),
   localparam int CW       = AW + 2,
   localparam int CLW      = $clog2(CMD_DEPTH) + 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 host_wr,
   input logic                 host_rd,
   input logic                 cmd_mode,
   input logic                 cmd_clr,
   input logic                 resp_load,
   input logic                 flush,
   input logic signed [CW-1:0] count,
   input logic                 irq_req,
   input logic [DATA_W-1:0]    host_rdata,
   input logic                 overrun,
   input logic [DATA_W-1:0]    flags,
   input logic [CLW-1:0]       cmd_len,
   input logic [AW-1:0]        wptr,
   input logic [AW-1:0]        rptr
);
   localparam logic signed [CW-1:0] LIMIT = CW'(DEPTH - 1);
   localparam logic signed [CW-1:0] ONE   = CW'(1);

   assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      count >= 0 && count <= LIMIT);

   assert_empty_ptrs_R8: assert property (@(posedge clk) disable iff (!rst_n)
      count == 0 |-> wptr == '0 && rptr == '0);

   assert_overrun_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      overrun && !flush |=> overrun);

   assert_read_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd && !resp_load && count > 0 |=> irq_req && count == $past(count) - ONE);

   assert_empty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd && !resp_load && count == 0 |=> !irq_req && $stable(host_rdata) && count == 0);

   assert_resp_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      resp_load |=> count == CW'(2) && flags == DATA_W'(2) && rptr == '0);

   assert_capture_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && !host_rd && !resp_load && cmd_mode |=> $stable(count));

   assert_capture_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && !host_rd && !resp_load && cmd_mode && !cmd_clr && cmd_len < CLW'(CMD_DEPTH)
      |=> cmd_len == $past(cmd_len) + CLW'(1));

   assert_rd_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd && host_wr && !resp_load && count == 0 |=> count == 0);
endmodule

bind pio_fifo pio_fifo_chk #(.DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_wr    (host_wr),
   .host_rd    (host_rd),
   .cmd_mode   (cmd_mode),
   .cmd_clr    (cmd_clr),
   .resp_load  (resp_load),
   .flush      (flush),
   .count      (count),
   .irq_req    (irq_req),
   .host_rdata (host_rdata),
   .overrun    (overrun),
   .flags      (flags),
   .cmd_len    (cmd_len),
   .wptr       (s_wptr),
   .rptr       (s_rptr)
);

// File: tb/pio_fifo_bench.sv
module pio_fifo_bench;
   localparam int DEPTH = 16;
   localparam int CMDD  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_wr = 0, host_rd = 0, cmd_mode = 0, cmd_clr = 0, resp_load = 0, flush = 0;
   logic [7:0] host_wdata = 0, resp_code = 0;
   logic [1:0] phase_hi = 2'b01;
   logic [3:0] cmd_raddr = 0;
   logic [7:0] host_rdata, cmd_rdata, flags;
   logic [4:0] cmd_len;
   logic signed [5:0] count;
   logic overrun, irq_req;

   always #2 clk = ~clk;

   pio_fifo u_pio_fifo (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .phase_hi(phase_hi),
      .cmd_mode(cmd_mode), .cmd_clr(cmd_clr), .cmd_raddr(cmd_raddr),
      .cmd_rdata(cmd_rdata), .cmd_len(cmd_len), .resp_load(resp_load),
      .resp_code(resp_code), .flush(flush), .count(count), .overrun(overrun),
      .flags(flags), .irq_req(irq_req)
   );

   int checks = 0, fails = 0;
   bit done = 0;

   int m_mem [DEPTH];
   int m_cmd [CMDD];
   int m_rptr = 0, m_wptr = 0, m_cnt = 0, m_len = 0, m_rdata = 0, m_flags = 0;
   bit m_ovr = 0, m_irq = 0;

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic string tag_of(bit wr, bit rd, bit cm, bit [1:0] ph, bit rl, bit fl);
      if (rl) return "R9";
      if (rd && wr) return "R10";
      if (rd && m_cnt == 0) return "R7";
      if (rd && m_cnt == 1) return "R8";
      if (rd && ph == 2'b00) return "R6";
      if (rd) return "R5";
      if (wr && cm) return "R4";
      if ((wr && m_cnt == DEPTH - 1) || fl) return "R3";
      return "R2";
   endfunction

   task automatic model(bit wr, bit rd, int d, bit cm, bit [1:0] ph, bit rl, int code, bit fl, bit cc);
      m_irq = 0;
      if (rl) begin
         m_mem[0] = code; m_mem[1] = 0;
         m_rptr = 0; m_wptr = 0; m_cnt = 2;
      end else if (rd) begin
         if (m_cnt > 0) begin
            m_cnt--; m_irq = 1;
            if (ph == 2'b00) m_rdata = 0;
            else begin m_rdata = m_mem[m_rptr]; m_rptr = (m_rptr + 1) % DEPTH; end
            if (m_cnt == 0) begin m_rptr = 0; m_wptr = 0; end
         end
      end else if (wr) begin
         if (cm) begin
            if (!cc && m_len < CMDD) begin m_cmd[m_len] = d; m_len++; end
         end else if (m_cnt == DEPTH - 1) m_ovr = 1;
         else begin m_mem[m_wptr] = d; m_wptr = (m_wptr + 1) % DEPTH; m_cnt++; end
      end
      if (cc) m_len = 0;
      if (fl) m_ovr = 0;
      if (rl) m_flags = 2; else if (fl) m_flags = 0;
   endtask

   task automatic step(bit wr, bit rd, int d, bit cm, bit [1:0] ph,
                       bit rl = 0, int code = 0, bit fl = 0, bit cc = 0);
      string t;
      int ra;
      @(negedge clk);
      ra = (m_len > 0) ? $urandom_range(0, m_len - 1) : 0;
      host_wr = wr; host_rd = rd; host_wdata = d[7:0]; cmd_mode = cm; phase_hi = ph;
      resp_load = rl; resp_code = code[7:0]; flush = fl; cmd_clr = cc; cmd_raddr = ra[3:0];
      t = tag_of(wr, rd, cm, ph, rl, fl);
      @(posedge clk);
      model(wr, rd, d, cm, ph, rl, code, fl, cc);
      #1;
      host_wr = 0; host_rd = 0; resp_load = 0; flush = 0; cmd_clr = 0;
      chk(t, "count", int'(count), m_cnt);
      chk(t, "rdata", int'(host_rdata), m_rdata);
      chk(t, "irq_req R11", int'(irq_req), int'(m_irq));
      chk(t, "overrun", int'(overrun), int'(m_ovr));
      chk(t, "flags", int'(flags), m_flags);
      chk(t, "cmd_len", int'(cmd_len), m_len);
      if (ra < m_len) chk("R4", "cmd_rdata", int'(cmd_rdata), m_cmd[ra]);
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
      for (int i = 0; i < CMDD; i++) m_cmd[i] = 0;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "reset count", int'(count), 0);
      chk("R1", "reset rdata", int'(host_rdata), 0);
      chk("R1", "reset irq", int'(irq_req), 0);
      chk("R1", "reset overrun", int'(overrun), 0);
      chk("R1", "reset flags", int'(flags), 0);
      chk("R1", "reset cmd_len", int'(cmd_len), 0);
      @(negedge clk); rst_n = 1;

      // R7: read of empty FIFO
      step(0, 1, 0, 0, 2'b01);
      // R2, R3: fill to limit, then overrun, then flush
      for (int i = 0; i < DEPTH - 1; i++) step(1, 0, 8'h10 + i, 0, 2'b01);
      step(1, 0, 8'hEE, 0, 2'b01);
      step(0, 0, 0, 0, 2'b01);
      step(0, 0, 0, 0, 2'b01, 0, 0, 1);
      // R6: data-out reads do not move the pointer; R2 order
      step(0, 1, 0, 0, 2'b00);
      step(0, 1, 0, 0, 2'b10);
      chk("R6", "byte after data-out read", int'(host_rdata), 8'h10);
      for (int i = 0; i < DEPTH - 3; i++) step(0, 1, 0, 0, 2'b11);
      // R8: pointers snap back to slot 0
      step(1, 0, 8'hA1, 0, 2'b01);
      step(1, 0, 8'hA2, 0, 2'b01);
      step(0, 1, 0, 0, 2'b00);
      step(0, 1, 0, 0, 2'b01);
      step(1, 0, 8'hC3, 0, 2'b01);
      step(0, 1, 0, 0, 2'b01);
      chk("R8", "byte after snap-back", int'(host_rdata), 8'hC3);
      // R9: response load overrides host access, beats flush for flags
      step(1, 1, 8'h55, 0, 2'b01, 1, 8'h3C, 1);
      step(0, 1, 0, 0, 2'b11);
      chk("R9", "status byte", int'(host_rdata), 8'h3C);
      step(0, 1, 0, 0, 2'b11);
      chk("R9", "second byte", int'(host_rdata), 0);
      // R10: simultaneous read and write
      step(1, 0, 8'h77, 0, 2'b01);
      step(1, 1, 8'h99, 0, 2'b01);
      chk("R10", "write ignored count", int'(count), 0);
      // R4: command capture to its limit, then clear
      for (int i = 0; i < CMDD + 2; i++) step(1, 0, 8'h80 + i, 1, 2'b01);
      step(1, 0, 8'h44, 1, 2'b01, 0, 0, 0, 1);
      chk("R4", "cleared len", int'(cmd_len), 0);

      // constrained random epochs
      for (int e = 0; e < 30; e++) begin
         int wb = $urandom_range(15, 90);
         bit cm = ($urandom_range(0, 9) < 2);
         for (int k = 0; k < 100; k++) begin
            bit wr = ($urandom_range(0, 99) < wb);
            bit rd = ($urandom_range(0, 99) < (100 - wb));
            bit rl = ($urandom_range(0, 99) < 2);
            bit fl = ($urandom_range(0, 99) < 3);
            bit cc = cm && ($urandom_range(0, 99) < 4);
            step(wr, rd, $urandom_range(0, 255), cm, 2'($urandom_range(0, 3)),
                 rl, $urandom_range(0, 255), fl, cc);
         end
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule